// File: doc/BRIEF.md
# Multicycle Processor Phase Sequencer

This block is the central control state machine of a small multicycle 16-bit load/store processor. Every instruction passes through a series of phases: fetch, decode, then one of three execution paths (ALU work, branch-target computation, or memory-address computation), with optional memory traffic, a register-file write and a program-counter update. The sequencer holds the current phase in a register and publishes it as a 4-bit code. Every datapath block compares this code against the fixed values listed below to decide when it acts.

The sequencer does not decode instructions. A decoder supplies a 6-bit control bundle with four fields. The instruction type sits in bits [5:4], the store-PC flag in bit [3], the memory-access mode in bits [2:1] and the load flag in bit [0]. The memory supplies a completion flag. The sequencer reads only the fields that matter in the current phase. Every phase that uses the memory bus stays where it is until completion is reported. Reset is synchronous and active high.

Top module: `phase_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the state after that edge is FETCH. State codes are: FETCH=0, DECODE=1, ALU=2, TARGET=3, ADDR=4, INDIRECT=5, MEMREAD=6, MEMWRITE=7, REGWRITE=8, PCUPDATE=9, INVALID=15.
- R2: In FETCH the state holds while `mem_done_i` is 0 and moves to DECODE when it is 1.
- R3: In DECODE, instruction type `ctrl_i[5:4]` selects the next state: 0 gives ALU, 1 gives TARGET, 2 gives ADDR and 3 gives INVALID.
- R4: In TARGET, store-PC `ctrl_i[3]`=1 gives REGWRITE and 0 gives PCUPDATE.
- R5: In ADDR, mode `ctrl_i[2:1]` selects the next state: 0 gives MEMREAD, 1 gives MEMWRITE, 2 gives INDIRECT and 3 gives REGWRITE.
- R6: In INDIRECT the state holds while `mem_done_i` is 0. When it is 1, load `ctrl_i[0]`=1 gives MEMREAD and 0 gives MEMWRITE.
- R7: MEMREAD and MEMWRITE hold while `mem_done_i` is 0. When it is 1, MEMREAD goes to REGWRITE and MEMWRITE goes to PCUPDATE.
- R8: ALU and REGWRITE go unconditionally to REGWRITE and PCUPDATE respectively, and PCUPDATE goes to FETCH.
- R9: INVALID is left only through reset.
- R10: In ALU, REGWRITE, PCUPDATE and INVALID neither input affects the next state. In FETCH, MEMREAD and MEMWRITE `ctrl_i` has no effect. In DECODE, TARGET and ADDR `mem_done_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_i | input | 6 | Decoded control bundle {type[1:0], store_pc, mode[1:0], load} |
| mem_done_i | input | 1 | Memory completion flag |
| state_o | output | 4 | Current phase code |

## Verification
The state register sits directly between the inputs and `state_o`. Every transition therefore shows up exactly one rising edge after the inputs that caused it, and a reset shows up on the first edge at which it is high. The bench changes `ctrl_i` and `mem_done_i` on the falling edge. It compares `state_o` on the next falling edge, which falls after exactly one rising edge, and only then applies the next stimulus. Each vector therefore tests one transition from a known state. The bench walks every execution path, holds each memory phase with completion low, and drives bits that are irrelevant in the current phase to show that they have no effect.

// File: rtl/phase_pkg.sv
package phase_pkg;
  localparam int STATE_W = 4;
  localparam int TYPE_W  = 2;
  localparam int MODE_W  = 2;
  localparam int CTRL_W  = TYPE_W + 1 + MODE_W + 1;

  typedef enum logic [STATE_W-1:0] {
    PH_FETCH    = 4'd0,
    PH_DECODE   = 4'd1,
    PH_ALU      = 4'd2,
    PH_TARGET   = 4'd3,
    PH_ADDR     = 4'd4,
    PH_INDIRECT = 4'd5,
    PH_MEMREAD  = 4'd6,
    PH_MEMWRITE = 4'd7,
    PH_REGWRITE = 4'd8,
    PH_PCUPDATE = 4'd9,
    PH_INVALID  = 4'd15
  } phase_e;

  typedef enum logic [TYPE_W-1:0] {
    IT_ALU = 2'd0, IT_FLOW = 2'd1, IT_MEM = 2'd2, IT_BAD = 2'd3
  } itype_e;

  typedef enum logic [MODE_W-1:0] {
    MM_READ = 2'd0, MM_WRITE = 2'd1, MM_IND = 2'd2, MM_REG = 2'd3
  } mmode_e;

  typedef struct packed {
    itype_e itype;
    logic   store_pc;
    mmode_e mode;
    logic   load;
  } ctrl_t;

  // Phases that own the memory bus and wait for completion.
  function automatic logic is_mem_phase(phase_e p);
    return (p == PH_FETCH) || (p == PH_INDIRECT) ||
           (p == PH_MEMREAD) || (p == PH_MEMWRITE);
  endfunction

  // Transition function used by the next-state block.
  function automatic phase_e next_phase(phase_e cur, ctrl_t c, logic done);
    phase_e n;
    case (cur)
      PH_FETCH:    n = done ? PH_DECODE : PH_FETCH;
      PH_DECODE: begin
        case (c.itype)
          IT_ALU:  n = PH_ALU;
          IT_FLOW: n = PH_TARGET;
          IT_MEM:  n = PH_ADDR;
          default: n = PH_INVALID;
        endcase
      end
      PH_ALU:      n = PH_REGWRITE;
      PH_TARGET:   n = c.store_pc ? PH_REGWRITE : PH_PCUPDATE;
      PH_ADDR: begin
        case (c.mode)
          MM_READ:  n = PH_MEMREAD;
          MM_WRITE: n = PH_MEMWRITE;
          MM_IND:   n = PH_INDIRECT;
          default:  n = PH_REGWRITE;
        endcase
      end
      PH_INDIRECT: n = !done ? PH_INDIRECT : (c.load ? PH_MEMREAD : PH_MEMWRITE);
      PH_MEMREAD:  n = done ? PH_REGWRITE : PH_MEMREAD;
      PH_MEMWRITE: n = done ? PH_PCUPDATE : PH_MEMWRITE;
      PH_REGWRITE: n = PH_PCUPDATE;
      PH_PCUPDATE: n = PH_FETCH;
      default:     n = PH_INVALID;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/phase_fields.sv
module phase_fields
  import phase_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output ctrl_t             fields_o
);
  assign fields_o = ctrl_t'(ctrl_i);
endmodule

// File: rtl/phase_next.sv
module phase_next
  import phase_pkg::*;
(
  input  phase_e cur_i,
  input  ctrl_t  fields_i,
  input  logic   done_i,
  output phase_e nxt_o,
  output logic   wait_hold_o
);
  assign nxt_o       = next_phase(cur_i, fields_i, done_i);
  assign wait_hold_o = is_mem_phase(cur_i) && !done_i;
endmodule

// File: rtl/phase_state_reg.sv
module phase_state_reg
  import phase_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e nxt_i,
  output phase_e cur_o
);
  always_ff @(posedge clk) begin
    if (rst) cur_o <= PH_FETCH;
    else     cur_o <= nxt_i;
  end
endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer
  import phase_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [CTRL_W-1:0]  ctrl_i,
  input  logic               mem_done_i,
  output logic [STATE_W-1:0] state_o
);
  ctrl_t  fields;
  phase_e cur_phase;
  phase_e nxt_phase;
  logic   wait_hold;

  phase_fields u_fields (.ctrl_i(ctrl_i), .fields_o(fields));

  phase_next u_next (
    .cur_i(cur_phase), .fields_i(fields), .done_i(mem_done_i),
    .nxt_o(nxt_phase), .wait_hold_o(wait_hold)
  );

  phase_state_reg u_reg (.clk(clk), .rst(rst), .nxt_i(nxt_phase), .cur_o(cur_phase));

  assign state_o = cur_phase;

  // R1: reset lands in fetch
  p_reset_fetch_r1: assert property (@(posedge clk) rst |=> state_o == PH_FETCH);

  // R2, R6, R7: memory phases hold while completion is low
  p_wait_hold_r7: assert property (@(posedge clk) disable iff (rst)
    wait_hold |=> $stable(state_o));

  // R2: fetch with completion goes to decode
  p_fetch_adv_r2: assert property (@(posedge clk) disable iff (rst)
    (state_o == PH_FETCH && mem_done_i) |=> state_o == PH_DECODE);

  // R3: decode never stays in decode
  p_decode_leave_r3: assert property (@(posedge clk) disable iff (rst)
    state_o == PH_DECODE |=> state_o != PH_DECODE);

  // R8: program-counter update always returns to fetch
  p_pc_to_fetch_r8: assert property (@(posedge clk) disable iff (rst)
    state_o == PH_PCUPDATE |=> state_o == PH_FETCH);

  // R9: invalid is sticky
  p_invalid_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    state_o == PH_INVALID |=> state_o == PH_INVALID);

  // R1: only documented codes appear
  p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
    (state_o <= 4'd9) || (state_o == 4'd15));
endmodule

// File: tb/phase_sequencer_tb_top.sv
module phase_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 48;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] ctrl;
  logic       done;
  logic [3:0] state;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_sequencer dut_i (.clk(clk), .rst(rst), .ctrl_i(ctrl), .mem_done_i(done), .state_o(state));

  // {req[3:0], ctrl[5:0], done, expected state after one rising edge}
  localparam logic [14:0] VEC [0:NV-1] = '{
    {4'd2,  6'b00_0000, 1'b0, 4'd0},  // R2 fetch holds
    {4'd2,  6'b11_1111, 1'b1, 4'd1},  // R2 fetch -> decode, R10 ctrl ignored
    {4'd3,  6'b00_0000, 1'b0, 4'd2},  // R3 type 0 -> alu
    {4'd10, 6'b11_1111, 1'b0, 4'd8},  // R8 R10 alu -> regwrite
    {4'd10, 6'b11_1111, 1'b1, 4'd9},  // R8 regwrite -> pcupdate
    {4'd8,  6'b10_0110, 1'b0, 4'd0},  // R8 pcupdate -> fetch
    {4'd2,  6'b00_0000, 1'b1, 4'd1},
    {4'd3,  6'b01_1000, 1'b0, 4'd3},  // R3 type 1 -> target
    {4'd4,  6'b01_1000, 1'b0, 4'd8},  // R4 store_pc=1
    {4'd8,  6'b00_0000, 1'b0, 4'd9},
    {4'd8,  6'b00_0000, 1'b0, 4'd0},
    {4'd2,  6'b00_0000, 1'b1, 4'd1},
    {4'd10, 6'b01_0000, 1'b1, 4'd3},  // R10 done ignored in decode
    {4'd4,  6'b01_0111, 1'b1, 4'd9},  // R4 store_pc=0 -> pcupdate
    {4'd8,  6'b00_0000, 1'b0, 4'd0},
    {4'd2,  6'b00_0000, 1'b1, 4'd1},
    {4'd3,  6'b10_0000, 1'b0, 4'd4},  // R3 type 2 -> addr
    {4'd5,  6'b10_0000, 1'b0, 4'd6},  // R5 mode 0 -> memread
    {4'd7,  6'b11_1111, 1'b0, 4'd6},  // R7 memread holds, R10
    {4'd7,  6'b00_0000, 1'b1, 4'd8},  // R7 memread -> regwrite
    {4'd8,  6'b00_0000, 1'b0, 4'd9},
    {4'd8,  6'b00_0000, 1'b0, 4'd0},
    {4'd2,  6'b00_0000, 1'b1, 4'd1},
    {4'd3,  6'b10_0010, 1'b0, 4'd4},
    {4'd5,  6'b10_0010, 1'b1, 4'd7},  // R5 mode 1 -> memwrite
    {4'd7,  6'b00_0000, 1'b0, 4'd7},  // R7 memwrite holds
    {4'd7,  6'b00_0000, 1'b1, 4'd9},  // R7 memwrite -> pcupdate
    {4'd8,  6'b00_0000, 1'b0, 4'd0},
    {4'd2,  6'b00_0000, 1'b1, 4'd1},
    {4'd3,  6'b10_0100, 1'b0, 4'd4},
    {4'd5,  6'b10_0100, 1'b0, 4'd5},  // R5 mode 2 -> indirect
    {4'd6,  6'b10_0101, 1'b0, 4'd5},  // R6 indirect holds
    {4'd6,  6'b10_0101, 1'b1, 4'd6},  // R6 load=1 -> memread
    {4'd7,  6'b00_0000, 1'b1, 4'd8},
    {4'd8,  6'b00_0000, 1'b0, 4'd9},
    {4'd8,  6'b00_0000, 1'b0, 4'd0},
    {4'd2,  6'b00_0000, 1'b1, 4'd1},
    {4'd3,  6'b10_0100, 1'b0, 4'd4},
    {4'd5,  6'b10_0100, 1'b0, 4'd5},
    {4'd6,  6'b10_0100, 1'b1, 4'd7},  // R6 load=0 -> memwrite
    {4'd7,  6'b00_0000, 1'b1, 4'd9},
    {4'd8,  6'b00_0000, 1'b0, 4'd0},
    {4'd2,  6'b00_0000, 1'b1, 4'd1},
    {4'd3,  6'b10_0110, 1'b0, 4'd4},
    {4'd5,  6'b10_0110, 1'b0, 4'd8},  // R5 mode 3 -> regwrite
    {4'd8,  6'b00_0000, 1'b0, 4'd9},
    {4'd8,  6'b00_0000, 1'b0, 4'd0},
    {4'd2,  6'b00_0000, 1'b1, 4'd1}
  };

  task automatic check(input int req, input logic [3:0] exp);
    checks++;
    if (state !== exp) begin
      errors++;
      $display("FAIL R%0d: state=%0d expected=%0d", req, state, exp);
    end
  endtask

  // Drive on the falling edge, let one rising edge pass, compare on the next falling edge.
  task automatic step(input logic r, input logic [5:0] c, input logic d,
                      input int req, input logic [3:0] exp);
    rst = r; ctrl = c; done = d;
    @(negedge clk);
    check(req, exp);
  endtask

  initial begin
    rst = 1'b1; ctrl = '0; done = 1'b0;
    @(negedge clk);
    check(1, 4'd0);                        // R1 reset state
    @(negedge clk);
    for (int i = 0; i < NV; i++)
      step(1'b0, VEC[i][10:5], VEC[i][4], int'(VEC[i][14:11]), VEC[i][3:0]);
    // R3 type 3 -> invalid; R9 sticky under any inputs
    step(1'b0, 6'b11_0000, 1'b0, 3, 4'd15);
    step(1'b0, 6'b00_0000, 1'b1, 9, 4'd15);
    step(1'b0, 6'b01_1000, 1'b1, 9, 4'd15);
    step(1'b0, 6'b10_0101, 1'b0, 9, 4'd15);
    step(1'b1, 6'b11_1111, 1'b1, 1, 4'd0); // R1 reset leaves invalid
    // R1 reset in the middle of a memory wait
    step(1'b0, 6'b00_0000, 1'b1, 2, 4'd1);
    step(1'b0, 6'b10_0000, 1'b0, 3, 4'd4);
    step(1'b0, 6'b10_0000, 1'b0, 5, 4'd6);
    step(1'b1, 6'b00_0000, 1'b0, 1, 4'd0);
    step(1'b1, 6'b00_0000, 1'b1, 1, 4'd0); // R1 reset overrides completion
    step(1'b0, 6'b00_0000, 1'b0, 2, 4'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule